// File: doc/BRIEF.md
# Dual-Bank Disk Controller Port Front End

This block is the byte-wide register front end that a host processor sees when it talks to a floppy disk controller. It answers two identical groups of eight port addresses. The first group serves the double-density drives and the second, sixteen addresses higher, serves the single-density drives. Each group has its own status register. Both groups share one result type, two result bytes, a ready-change flag and a single interrupt flip-flop.

The host points the controller at a parameter block in two writes. The low-address write loads the low byte and clears the upper byte. The high-address write ORs its data into the upper byte and launches the command engine with a one-cycle start pulse. When the engine reports completion, its results are captured here. If the engine also raises its interrupt flag, the interrupt is raised and the status register of the bank that issued the command shows it. Reading the result type takes the interrupt down again. A write to offset 7 of either bank re-initialises the front end.

Top module: `fdc_port_front`

## Requirements
- R1: After hardware reset, status uses this encoding: bit0 present, bit1 ready of the bank's first drive, bit2 interrupt, bit3 double density, bit4/bit5/bit6 ready of the second/third/fourth drive, bit7 zero. The double-density status shows present, density and the ready bits of attached drives 0-3. The single-density status shows present and the ready bits of drives 4-5 (drive 4 at bit1, drive 5 at bit4). The result type and result byte 0 read 0x00 and `irq` is low.
- R2: Ports decode at offsets from BASE_ADDR (double-density bank) and BASE_ADDR+16 (single-density bank): 0 status, 1 result type (read) / address low (write), 2 address high and start (write), 3 result byte (read), 7 reset (write). Read data appears on `port_rdata` the cycle after `port_rd`. The value is 0x00 for an unused offset, for a write-only offset, and for an address outside both banks.
- R3: A write to offset 1 sets `cmd_iopb` to {0x00, data}. A write to offset 2 ORs the data into `cmd_iopb[15:8]`, and `cmd_start` is high for exactly the following cycle.
- R4: A write to offset 2 while `eng_busy` is high, or while an earlier start has not yet seen `eng_done`, produces no start and leaves `cmd_iopb` unchanged.
- R5: On `eng_done` the result type, both result bytes and the ready-change flag are captured. If `eng_irq_flag` is also high, `irq` rises and status bit2 is set in the bank that issued the command only.
- R6: Reading offset 1 of either bank returns the result type and clears `irq` and both status interrupt bits. A completion in the same cycle wins.
- R7: Reading offset 3 returns result byte 0 when the result type is 0x00. Otherwise it returns result byte 1 if the ready-change flag is set, and result byte 0 if it is not.
- R8: A write to offset 7 of either bank reloads both status registers from `drive_attached` as in R1. It clears the result type, result byte 0, the ready-change flag and `irq`. Result byte 1 bit k is set when double-density drive k or single-density drive k is attached.
- R9: Writes to offsets 0, 3, 4, 5 and 6 change no state: status, `cmd_iopb` and `cmd_start` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 8 | Host port address |
| port_rd | input | 1 | Host read strobe, one cycle per access |
| port_wr | input | 1 | Host write strobe, one cycle per access |
| port_wdata | input | 8 | Host write data |
| port_rdata | output | 8 | Registered host read data |
| drive_attached | input | 6 | Drives 0-3 double density, 4-5 single density; sampled at reset |
| eng_busy | input | 1 | Command engine cannot accept a start |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_irq_flag | input | 1 | Engine requests an interrupt with this completion |
| eng_rtype | input | 8 | Result type from the engine |
| eng_rbyte0 | input | 8 | Result byte 0 from the engine |
| eng_rbyte1 | input | 8 | Result byte 1 from the engine |
| eng_rdychg | input | 1 | Ready-change flag from the engine |
| cmd_start | output | 1 | One-cycle start pulse to the engine |
| cmd_iopb | output | 16 | Parameter-block address for the engine |
| irq | output | 1 | Interrupt flip-flop |

## Verification
The properties assume the host never raises `port_rd` and `port_wr` together, and that the engine pulses `eng_done` for a single cycle. The stimulus drives every host access as a one-cycle strobe from a task, so the two strobes never overlap. Engine completions are likewise issued one cycle at a time. Completions arriving with no command in flight are allowed and exercised, because the capture path must accept them.

// File: rtl/fdc_pf_pkg.sv
package fdc_pf_pkg;

    typedef enum logic {
        BANK_DD = 1'b0,
        BANK_SD = 1'b1
    } bank_e;

    localparam logic [2:0] OFF_STATUS = 3'd0;
    localparam logic [2:0] OFF_RTYPE  = 3'd1;
    localparam logic [2:0] OFF_ADRHI  = 3'd2;
    localparam logic [2:0] OFF_RESULT = 3'd3;
    localparam logic [2:0] OFF_RESET  = 3'd7;

    localparam int ST_PRESENT = 0;
    localparam int ST_INT     = 2;
    localparam int ST_DENS    = 3;

    typedef struct packed {
        logic       rd_hit;
        logic       wr_hit;
        bank_e      bank;
        logic [2:0] off;
    } port_dec_t;

    // status bit that carries the ready flag of the i-th drive of a bank
    function automatic int rdy_pos(input int i);
        case (i)
            0:       rdy_pos = 1;
            1:       rdy_pos = 4;
            2:       rdy_pos = 5;
            default: rdy_pos = 6;
        endcase
    endfunction

endpackage

// File: rtl/fdc_pf_decode.sv
module fdc_pf_decode
    import fdc_pf_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h78,
    parameter int                BANK_STRIDE = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output port_dec_t         dec
);
    localparam int                BANK_SPAN = 8;
    localparam logic [ADDR_W-1:0] SPAN_A    = ADDR_W'(BANK_SPAN);
    localparam logic [ADDR_W-1:0] SD_LO     = ADDR_W'(BANK_STRIDE);
    localparam logic [ADDR_W-1:0] SD_HI     = ADDR_W'(BANK_STRIDE + BANK_SPAN);

    logic [ADDR_W-1:0] rel;
    logic              in_dd;
    logic              in_sd;

    always_comb begin
        rel    = addr - BASE_ADDR;
        in_dd  = (rel < SPAN_A);
        in_sd  = (rel >= SD_LO) && (rel < SD_HI);
        dec.rd_hit = rd && (in_dd || in_sd);
        dec.wr_hit = wr && (in_dd || in_sd);
        dec.bank   = in_sd ? BANK_SD : BANK_DD;
        dec.off    = rel[2:0];
    end
endmodule

// File: rtl/fdc_pf_status.sv
module fdc_pf_status
    import fdc_pf_pkg::*;
#(
    parameter int NDD = 4,
    parameter int NSD = 2
) (
    input  logic [NDD-1:0] rdy_dd,
    input  logic [NSD-1:0] rdy_sd,
    input  logic           int_dd,
    input  logic           int_sd,
    output logic [7:0]     stat_dd,
    output logic [7:0]     stat_sd
);
    always_comb begin
        stat_dd = '0;
        stat_sd = '0;
        stat_dd[ST_PRESENT] = 1'b1;
        stat_dd[ST_DENS]    = 1'b1;
        stat_dd[ST_INT]     = int_dd;
        stat_sd[ST_PRESENT] = 1'b1;
        stat_sd[ST_INT]     = int_sd;
        for (int i = 0; i < NDD; i++) stat_dd[rdy_pos(i)] = rdy_dd[i];
        for (int j = 0; j < NSD; j++) stat_sd[rdy_pos(j)] = rdy_sd[j];
    end
endmodule

// File: rtl/fdc_pf_rdmux.sv
module fdc_pf_rdmux
    import fdc_pf_pkg::*;
(
    input  logic       rd_hit,
    input  bank_e      bank,
    input  logic [2:0] off,
    input  logic [7:0] stat_dd,
    input  logic [7:0] stat_sd,
    input  logic [7:0] rtype,
    input  logic [7:0] rbyte0,
    input  logic [7:0] rbyte1,
    input  logic       rdychg,
    output logic [7:0] value
);
    logic [7:0] result_sel;

    always_comb begin
        if (rtype == 8'h00)  result_sel = rbyte0;
        else if (rdychg)     result_sel = rbyte1;
        else                 result_sel = rbyte0;

        value = 8'h00;
        if (rd_hit) begin
            case (off)
                OFF_STATUS: value = (bank == BANK_SD) ? stat_sd : stat_dd;
                OFF_RTYPE:  value = rtype;
                OFF_RESULT: value = result_sel;
                default:    value = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/fdc_port_front.sv
module fdc_port_front
    import fdc_pf_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h78,
    parameter int                BANK_STRIDE = 16,
    parameter int                NDD         = 4,
    parameter int                NSD         = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    port_addr,
    input  logic                 port_rd,
    input  logic                 port_wr,
    input  logic [7:0]           port_wdata,
    output logic [7:0]           port_rdata,
    input  logic [NDD+NSD-1:0]   drive_attached,
    input  logic                 eng_busy,
    input  logic                 eng_done,
    input  logic                 eng_irq_flag,
    input  logic [7:0]           eng_rtype,
    input  logic [7:0]           eng_rbyte0,
    input  logic [7:0]           eng_rbyte1,
    input  logic                 eng_rdychg,
    output logic                 cmd_start,
    output logic [15:0]          cmd_iopb,
    output logic                 irq
);
    localparam int NDRV = NDD + NSD;

    typedef struct packed {
        logic [15:0]    iopb;
        logic [7:0]     rtype;
        logic [7:0]     rbyte0;
        logic [7:0]     rbyte1;
        logic [7:0]     rdata;
        logic           rdychg;
        logic           intff;
        logic           inflight;
        logic           start;
        bank_e          start_bank;
        bank_e          int_bank;
        logic [NDD-1:0] rdy_dd;
        logic [NSD-1:0] rdy_sd;
    } fe_state_t;

    fe_state_t st_d, st_q;
    port_dec_t dec;
    logic [7:0] stat_dd, stat_sd, rd_value;

    function automatic logic [7:0] ready_map(input logic [NDRV-1:0] att);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < NDD; i++) m[i] = m[i] | att[i];
        for (int j = 0; j < NSD; j++) m[j] = m[j] | att[NDD+j];
        return m;
    endfunction

    fdc_pf_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .BANK_STRIDE(BANK_STRIDE)
    ) u_decode (
        .addr(port_addr), .rd(port_rd), .wr(port_wr), .dec(dec)
    );

    fdc_pf_status #(.NDD(NDD), .NSD(NSD)) u_status (
        .rdy_dd (st_q.rdy_dd),
        .rdy_sd (st_q.rdy_sd),
        .int_dd (st_q.intff && (st_q.int_bank == BANK_DD)),
        .int_sd (st_q.intff && (st_q.int_bank == BANK_SD)),
        .stat_dd(stat_dd),
        .stat_sd(stat_sd)
    );

    fdc_pf_rdmux u_rdmux (
        .rd_hit (dec.rd_hit),
        .bank   (dec.bank),
        .off    (dec.off),
        .stat_dd(stat_dd),
        .stat_sd(stat_sd),
        .rtype  (st_q.rtype),
        .rbyte0 (st_q.rbyte0),
        .rbyte1 (st_q.rbyte1),
        .rdychg (st_q.rdychg),
        .value  (rd_value)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.rdata = rd_value;

        // result-type read drops the interrupt
        if (dec.rd_hit && dec.off == OFF_RTYPE) st_d.intff = 1'b0;

        // engine completion captures results and may raise the interrupt
        if (eng_done) begin
            st_d.rtype    = eng_rtype;
            st_d.rbyte0   = eng_rbyte0;
            st_d.rbyte1   = eng_rbyte1;
            st_d.rdychg   = eng_rdychg;
            st_d.inflight = 1'b0;
            if (eng_irq_flag) begin
                st_d.intff    = 1'b1;
                st_d.int_bank = st_q.start_bank;
            end
        end

        if (dec.wr_hit) begin
            case (dec.off)
                OFF_RTYPE: st_d.iopb = {8'h00, port_wdata};
                OFF_ADRHI: begin
                    if (!eng_busy && !st_q.inflight) begin
                        st_d.iopb[15:8] = st_q.iopb[15:8] | port_wdata;
                        st_d.start      = 1'b1;
                        st_d.inflight   = 1'b1;
                        st_d.start_bank = dec.bank;
                    end
                end
                OFF_RESET: begin
                    st_d.rtype  = 8'h00;
                    st_d.rbyte0 = 8'h00;
                    st_d.rbyte1 = ready_map(drive_attached);
                    st_d.rdychg = 1'b0;
                    st_d.intff  = 1'b0;
                    st_d.rdy_dd = drive_attached[NDD-1:0];
                    st_d.rdy_sd = drive_attached[NDD +: NSD];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.start_bank <= BANK_DD;
            st_q.int_bank   <= BANK_DD;
            st_q.rbyte1     <= ready_map(drive_attached);
            st_q.rdy_dd     <= drive_attached[NDD-1:0];
            st_q.rdy_sd     <= drive_attached[NDD +: NSD];
        end else begin
            st_q <= st_d;
        end
    end

    assign port_rdata = st_q.rdata;
    assign cmd_start  = st_q.start;
    assign cmd_iopb   = st_q.iopb;
    assign irq        = st_q.intff;

endmodule

// File: rtl/fdc_port_front_chk.sv
module fdc_port_front_chk #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h78,
    parameter int                BANK_STRIDE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] port_addr,
    input logic              port_rd,
    input logic              port_wr,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              eng_irq_flag,
    input logic              cmd_start,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] SD_BASE = BASE_ADDR + ADDR_W'(BANK_STRIDE);

    logic rt_read, hi_write, rst_write;
    assign rt_read   = port_rd && (port_addr == BASE_ADDR + ADDR_W'(1) || port_addr == SD_BASE + ADDR_W'(1));
    assign hi_write  = port_wr && (port_addr == BASE_ADDR + ADDR_W'(2) || port_addr == SD_BASE + ADDR_W'(2));
    assign rst_write = port_wr && (port_addr == BASE_ADDR + ADDR_W'(7) || port_addr == SD_BASE + ADDR_W'(7));

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    a_r3_start_after_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(hi_write));

    a_r4_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(!eng_busy));

    a_r5_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_irq_flag && !rst_write) |=> irq);

    a_r6_rtype_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_read && !(eng_done && eng_irq_flag)) |=> !irq);

    a_r8_soft_reset_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rst_write |=> !irq);

endmodule

bind fdc_port_front fdc_port_front_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .BANK_STRIDE(BANK_STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_rd(port_rd),
    .port_wr(port_wr), .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_irq_flag(eng_irq_flag), .cmd_start(cmd_start), .irq(irq)
);

// File: tb/fdc_port_front_bench.sv
module fdc_port_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_addr = '0;
    logic        port_rd = 1'b0;
    logic        port_wr = 1'b0;
    logic [7:0]  port_wdata = '0;
    logic [7:0]  port_rdata;
    logic [5:0]  drive_attached = 6'b01_1001;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_irq_flag = 1'b0;
    logic [7:0]  eng_rtype = '0, eng_rbyte0 = '0, eng_rbyte1 = '0;
    logic        eng_rdychg = 1'b0;
    logic        cmd_start;
    logic [15:0] cmd_iopb;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [7:0] DD = 8'h78;
    localparam logic [7:0] SD = 8'h88;

    always #4 clk = ~clk;

    fdc_port_front u_fdc_port_front (.*);

    // scoreboard for read data
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= port_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (port_rdata !== e) begin
                errors++;
                $display("FAIL %s: port_rdata=%02h expected=%02h", t, port_rdata, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        port_addr = a; port_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        port_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        port_addr = a; port_wdata = d; port_wr = 1'b1;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic done(input logic f, input logic [7:0] rt, input logic [7:0] b0,
                        input logic [7:0] b1, input logic rc);
        @(negedge clk);
        eng_done = 1'b1; eng_irq_flag = f; eng_rtype = rt;
        eng_rbyte0 = b0; eng_rbyte1 = b1; eng_rdychg = rc;
        @(negedge clk);
        eng_done = 1'b0; eng_irq_flag = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, e);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(irq, 0, "R1 irq after reset");
        chk(cmd_start, 0, "R1 start after reset");
        rd(DD + 0, 8'h4B, "R1 dd status");
        rd(SD + 0, 8'h03, "R1 sd status");
        rd(DD + 1, 8'h00, "R1 rtype");
        rd(DD + 3, 8'h00, "R1 rbyte0");
        // R2 decode
        rd(DD + 4, 8'h00, "R2 unused offset");
        rd(DD + 2, 8'h00, "R2 write-only offset");
        rd(DD + 8, 8'h00, "R2 outside banks");
        rd(SD + 7, 8'h00, "R2 reset offset read");
        // R3 address and start
        wr(DD + 1, 8'h34);
        chk(cmd_iopb, 16'h0034, "R3 low byte");
        wr(DD + 2, 8'h12);
        chk(cmd_start, 1, "R3 start pulse");
        chk(cmd_iopb, 16'h1234, "R3 full address");
        @(negedge clk);
        chk(cmd_start, 0, "R3 start one cycle");
        // R4 in-flight blocks start
        wr(DD + 1, 8'h55);
        wr(DD + 2, 8'h66);
        chk(cmd_start, 0, "R4 inflight no start");
        chk(cmd_iopb, 16'h0055, "R4 high byte ignored");
        // R5 completion from DD command
        done(1'b1, 8'h02, 8'h80, 8'hC5, 1'b1);
        chk(irq, 1, "R5 irq raised");
        rd(DD + 0, 8'h4F, "R5 dd int bit");
        rd(SD + 0, 8'h03, "R5 sd unaffected");
        rd(DD + 3, 8'hC5, "R7 rbyte1 on ready change");
        // R6 result type read clears
        rd(DD + 1, 8'h02, "R6 rtype value");
        chk(irq, 0, "R6 irq cleared");
        rd(DD + 0, 8'h4B, "R6 dd int bit cleared");
        // R4 busy blocks
        eng_busy = 1'b1;
        wr(SD + 1, 8'h00);
        wr(SD + 2, 8'h40);
        chk(cmd_start, 0, "R4 busy no start");
        chk(cmd_iopb, 16'h0000, "R4 busy address kept");
        eng_busy = 1'b0;
        wr(SD + 1, 8'h10);
        wr(SD + 2, 8'h20);
        chk(cmd_start, 1, "R3 sd bank start");
        chk(cmd_iopb, 16'h2010, "R3 sd bank address");
        done(1'b1, 8'h02, 8'h11, 8'h99, 1'b0);
        rd(SD + 0, 8'h07, "R5 sd int bit");
        rd(DD + 0, 8'h4B, "R5 dd unaffected");
        rd(SD + 3, 8'h11, "R7 rbyte0 no ready change");
        done(1'b0, 8'h00, 8'h22, 8'h33, 1'b1);
        rd(SD + 3, 8'h22, "R7 rbyte0 when rtype zero");
        chk(irq, 1, "R5 irq held without flag");
        rd(SD + 1, 8'h00, "R6 sd rtype read");
        chk(irq, 0, "R6 irq cleared via sd bank");
        // R9 writes to read-only offsets
        wr(DD + 0, 8'hFF);
        wr(DD + 3, 8'hFF);
        wr(DD + 5, 8'hFF);
        chk(cmd_start, 0, "R9 no start");
        chk(cmd_iopb, 16'h2010, "R9 address unchanged");
        rd(DD + 0, 8'h4B, "R9 dd status unchanged");
        rd(DD + 3, 8'h22, "R9 result unchanged");
        // R8 soft reset
        done(1'b1, 8'h02, 8'h44, 8'h55, 1'b1);
        chk(irq, 1, "R8 irq set before reset");
        drive_attached = 6'b10_0110;
        wr(SD + 7, 8'h00);
        chk(irq, 0, "R8 irq cleared");
        rd(DD + 0, 8'h39, "R8 dd status reload");
        rd(SD + 0, 8'h11, "R8 sd status reload");
        rd(DD + 1, 8'h00, "R8 rtype cleared");
        rd(DD + 3, 8'h00, "R8 rbyte0 cleared");
        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R2 all reads observed");
        summary();
    end
endmodule